// File: doc/BRIEF.md
# Microstep Phase-Current Sequencer

This block converts a train of step pulses into signed current setpoints for the two windings of a bipolar stepping motor. It keeps an electrical-angle index at the finest resolution of 1/32 step. A qualified rising edge of the step input moves that index forward or backward by the size that belongs to the selected resolution. The index then selects a signed percentage for winding A (cosine) and winding B (sine). The percentage is scaled by a torque code and driven out with a polarity bit for each winding.

A step prescaler can make the index advance only on every 2nd, 4th or 8th qualified edge. An angle-reset input returns the index to the 45° home position and raises a home flag. Standby mode and a low enable both force the setpoints off. A downstream reference generator turns the setpoints into winding currents.

Top module: `ustep_seq`

## Requirements
- R1: Only a rising edge of `step_in` (high now, low in the previous clock) can move the angle. A falling edge, or a level held high, leaves the angle unchanged.
- R2: The angle index runs from 0 to 127 and wraps modulo 128, which is 2.8125° per position. A step adds the step size when `dir_cw`=1 and subtracts it when `dir_cw`=0. The step size is 32 for full, 16 for both half-step styles, 8 for quarter, 4 for 1/8, 2 for 1/16 and 1 for 1/32. Changing the resolution keeps the current index.
- R3: Resolution code 000 is standby. In standby, step edges neither move the angle nor advance the prescaler, and both setpoints and both polarity bits are 0.
- R4: While `angle_rst` is high, the index is 16 (45°), step edges are ignored and the prescaler is cleared. At this position both windings read 100 in full step and half step A, and 71 in every other resolution.
- R5: With quadrant q = index/32 and k = index mod 32, B uses magnitude m(k) when q is even and m(32−k) when q is odd. A uses m(32−k) when q is even and m(k) when q is odd. B is negative for q = 2 and 3. A is negative for q = 1 and 2.
- R6: Full step (001) and half step A (010) give m=0 for k=0 and m=100 otherwise. Half step B (100) gives 0 for k=0, 100 for k=32 and 71 otherwise.
- R7: Quarter step (011) gives m = 0, 38, 71, 100, 100 for floor(k/8) = 0 to 4. 1/8 step (101) gives m = 0, 20, 38, 56, 71, 83, 96, 98, 100 for floor(k/4) = 0 to 8.
- R8: 1/32 step (111) gives m(k) = round(100·sin(k·90°/32)). 1/16 step (110) uses the same formula with k rounded down to an even value.
- R9: The torque code 00/01/10/11 scales each magnitude to floor(m·P/100), with P = 40, 60, 80 or 100.
- R10: Speed-divide code 00/01/10/11 moves the angle on every 1st, 2nd, 4th or 8th qualified rising edge, counted from the last prescaler clear.
- R11: When `enable` is 0, both setpoints and both polarity bits are 0, and the angle still follows step edges.
- R12: A polarity bit is 1 exactly when its winding's setpoint is above zero. A 1 means the OUT+ side is driven high and the OUT− side low.
- R13: `home` is 1 exactly when the index is 16. After `rst_n` the index is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_in | input | 1 | Step pulse, synchronous to clk |
| dir_cw | input | 1 | 1 = clockwise (index up), 0 = counter-clockwise |
| res_code | input | 3 | Step resolution, 000 = standby |
| torque_code | input | 2 | Current scale 40/60/80/100 % |
| div_code | input | 2 | Step prescaler 1/2/4/8 |
| enable | input | 1 | 0 forces setpoints off |
| angle_rst | input | 1 | Returns angle to 45° home |
| set_a | output | 8 | Signed winding A setpoint, percent |
| set_b | output | 8 | Signed winding B setpoint, percent |
| pol_a | output | 1 | Winding A positive drive |
| pol_b | output | 1 | Winding B positive drive |
| home | output | 1 | Angle is at the 45° home position |

## Verification
The bench runs full sweeps through every quadrant in both directions and compares every output on every clock. A wrong quadrant sign, a swapped cosine/sine mirror or an off-by-one at k=0 or k=32 therefore appears as a flipped or missing setpoint at a wrap.

Directed cases cover several situations:
- Odd indices reached under 1/16: a missing floor-to-even shows a one-position-ahead magnitude.
- The prescaler at divide-by-8: a miscount moves the angle on the wrong edge.
- A step held high across the release of `angle_rst`: a level-sensitive design would move off home.
- Standby and a low enable: a design that forgets to freeze the angle in standby, or to blank the outputs, is caught there.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int IDX_W  = 7;   // 1/32 step over one electrical cycle
  localparam int QTR_W  = 5;   // positions per quarter wave
  localparam int MAG_W  = 7;   // percent 0..100
  localparam int HOME_IDX = 16; // 45 degrees

  typedef enum logic [2:0] {
    RES_STBY = 3'd0, RES_FULL = 3'd1, RES_HALF_A = 3'd2, RES_QTR = 3'd3,
    RES_HALF_B = 3'd4, RES_8TH = 3'd5, RES_16TH = 3'd6, RES_32ND = 3'd7
  } res_e;

  function automatic logic [IDX_W-1:0] step_size(res_e r);
    case (r)
      RES_FULL:               return IDX_W'(32);
      RES_HALF_A, RES_HALF_B: return IDX_W'(16);
      RES_QTR:                return IDX_W'(8);
      RES_8TH:                return IDX_W'(4);
      RES_16TH:               return IDX_W'(2);
      RES_32ND:               return IDX_W'(1);
      default:                return '0;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] sine_pct(logic [QTR_W:0] k);
    case (k)
      6'd0: return 7'd0;    6'd1: return 7'd5;    6'd2: return 7'd10;
      6'd3: return 7'd15;   6'd4: return 7'd20;   6'd5: return 7'd24;
      6'd6: return 7'd29;   6'd7: return 7'd34;   6'd8: return 7'd38;
      6'd9: return 7'd43;   6'd10: return 7'd47;  6'd11: return 7'd51;
      6'd12: return 7'd56;  6'd13: return 7'd60;  6'd14: return 7'd63;
      6'd15: return 7'd67;  6'd16: return 7'd71;  6'd17: return 7'd74;
      6'd18: return 7'd77;  6'd19: return 7'd80;  6'd20: return 7'd83;
      6'd21: return 7'd86;  6'd22: return 7'd88;  6'd23: return 7'd90;
      6'd24: return 7'd92;  6'd25: return 7'd94;  6'd26: return 7'd96;
      6'd27: return 7'd97;  6'd28: return 7'd98;  6'd29: return 7'd99;
      6'd30: return 7'd100; 6'd31: return 7'd100; 6'd32: return 7'd100;
      default: return 7'd0;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] eighth_pct(logic [3:0] j);
    case (j)
      4'd0: return 7'd0;   4'd1: return 7'd20;  4'd2: return 7'd38;
      4'd3: return 7'd56;  4'd4: return 7'd71;  4'd5: return 7'd83;
      4'd6: return 7'd96;  4'd7: return 7'd98;  4'd8: return 7'd100;
      default: return 7'd0;
    endcase
  endfunction

  // magnitude for quarter-wave position k (0..32) under resolution r
  function automatic logic [MAG_W-1:0] wave_mag(res_e r, logic [QTR_W:0] k);
    case (r)
      RES_FULL, RES_HALF_A: return (k == 0) ? 7'd0 : 7'd100;
      RES_HALF_B: return (k == 0) ? 7'd0 : ((k == 6'd32) ? 7'd100 : 7'd71);
      RES_QTR: begin
        case (k[5:3])
          3'd0: return 7'd0;
          3'd1: return 7'd38;
          3'd2: return 7'd71;
          default: return 7'd100;
        endcase
      end
      RES_8TH:  return eighth_pct(k[5:2]);
      RES_16TH: return sine_pct({k[5:1], 1'b0});
      RES_32ND: return sine_pct(k);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] apply_torque(logic [MAG_W-1:0] m, logic [1:0] tq);
    logic [13:0] pct, prod;
    case (tq)
      2'b00: pct = 14'd40;
      2'b01: pct = 14'd60;
      2'b10: pct = 14'd80;
      default: pct = 14'd100;
    endcase
    prod = 14'(m) * pct;
    return MAG_W'(prod / 14'd100);
  endfunction
endpackage

// File: rtl/ustep_edge_div.sv
module ustep_edge_div #(
  parameter int DIVSEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_in,
  input  logic                hold,
  input  logic                clr,
  input  logic [DIVSEL_W-1:0] div_code,
  output logic                adv
);
  localparam int CNT_W = (1 << DIVSEL_W) - 1;

  logic             step_q;
  logic             rise, qual;
  logic [CNT_W-1:0] cnt, mask;

  assign rise = step_in & ~step_q;
  assign qual = rise & ~hold & ~clr;
  assign mask = CNT_W'((1 << div_code) - 1);
  assign adv  = qual && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      cnt    <= '0;
    end else begin
      step_q <= step_in;
      if (clr)       cnt <= '0;
      else if (qual) cnt <= cnt + 1'b1;
    end
  end

  AST_ADV_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (step_in && !hold && !clr)); // R1
  AST_HELD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !adv); // R1
  AST_PRESCALE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R10
endmodule

// File: rtl/ustep_angle.sv
module ustep_angle #(
  parameter int IDX_W = 7,
  parameter int HOME  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             dir_cw,
  input  logic             clr,
  input  logic [IDX_W-1:0] step_sz,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= IDX_W'(HOME);
    else if (clr)  idx <= IDX_W'(HOME);
    else if (adv)  idx <= dir_cw ? idx + step_sz : idx - step_sz;
  end

  AST_ANGLE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (($past(dir_cw) && idx == IDX_W'($past(idx) + $past(step_sz))) ||
                       (!$past(dir_cw) && idx == IDX_W'($past(idx) - $past(step_sz))))); // R2
  AST_ANGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(idx)); // R2
  AST_ANGLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == IDX_W'(HOME))); // R4
endmodule

// File: rtl/ustep_winding.sv
module ustep_winding
  import ustep_pkg::*;
#(
  parameter int SET_W   = 8,
  parameter bit IS_SINE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        idx,
  input  logic [2:0]              res,
  input  logic [1:0]              tq,
  input  logic                    enable,
  output logic signed [SET_W-1:0] set,
  output logic                    pol
);
  logic [1:0]             quad;
  logic [QTR_W-1:0]       k;
  logic [QTR_W:0]         k_eff;
  logic                   mirror, neg, off;
  logic [MAG_W-1:0]       mag, scaled;
  logic signed [SET_W-1:0] mag_s;

  assign quad = idx[IDX_W-1 -: 2];
  assign k    = idx[QTR_W-1:0];

  always_comb begin
    if (IS_SINE) begin
      mirror = quad[0];
      neg    = quad[1];
    end else begin
      mirror = ~quad[0];
      neg    = quad[1] ^ quad[0];
    end
  end

  assign k_eff  = mirror ? (6'd32 - {1'b0, k}) : {1'b0, k};
  assign mag    = wave_mag(res_e'(res), k_eff);
  assign scaled = apply_torque(mag, tq);
  assign off    = !enable || (res_e'(res) == RES_STBY);
  assign mag_s  = $signed(SET_W'(scaled));
  assign set    = off ? '0 : (neg ? -mag_s : mag_s);
  assign pol    = !off && !neg && (scaled != '0);

  AST_SET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (set <= SET_W'(100)) && (set >= -SET_W'(100))); // R9
  AST_POL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pol |-> (set > 0)); // R12
endmodule

// File: rtl/ustep_seq.sv
module ustep_seq
  import ustep_pkg::*;
#(
  parameter int SET_W    = 8,
  parameter int DIVSEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_in,
  input  logic                    dir_cw,
  input  logic [2:0]              res_code,
  input  logic [1:0]              torque_code,
  input  logic [DIVSEL_W-1:0]     div_code,
  input  logic                    enable,
  input  logic                    angle_rst,
  output logic signed [SET_W-1:0] set_a,
  output logic signed [SET_W-1:0] set_b,
  output logic                    pol_a,
  output logic                    pol_b,
  output logic                    home
);
  logic             standby, adv;
  logic [IDX_W-1:0] idx, step_sz;
  logic signed [SET_W-1:0] set_w [2];
  logic             pol_w [2];

  assign standby = (res_e'(res_code) == RES_STBY);
  assign step_sz = step_size(res_e'(res_code));

  ustep_edge_div #(.DIVSEL_W(DIVSEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .hold(standby),
    .clr(angle_rst), .div_code(div_code), .adv(adv));

  ustep_angle #(.IDX_W(IDX_W), .HOME(HOME_IDX)) u_angle (
    .clk(clk), .rst_n(rst_n), .adv(adv), .dir_cw(dir_cw),
    .clr(angle_rst), .step_sz(step_sz), .idx(idx));

  for (genvar w = 0; w < 2; w++) begin : g_wind
    ustep_winding #(.SET_W(SET_W), .IS_SINE(w == 1)) u_wind (
      .clk(clk), .rst_n(rst_n), .idx(idx), .res(res_code),
      .tq(torque_code), .enable(enable), .set(set_w[w]), .pol(pol_w[w]));
  end

  assign set_a = set_w[0];
  assign set_b = set_w[1];
  assign pol_a = pol_w[0];
  assign pol_b = pol_w[1];
  assign home  = (idx == IDX_W'(HOME_IDX));

  AST_STBY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (set_a == 0 && set_b == 0 && !pol_a && !pol_b)); // R3
  AST_STBY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !angle_rst) |=> $stable(idx)); // R3
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (set_a == 0 && set_b == 0 && !pol_a && !pol_b)); // R11
  AST_RST_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    angle_rst |=> home); // R4
endmodule

// File: tb/ustep_seq_bench.sv
module ustep_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_in = 1'b0, dir_cw = 1'b1, enable = 1'b0, angle_rst = 1'b0;
  logic [2:0] res_code = 3'd0;
  logic [1:0] torque_code = 2'd3, div_code = 2'd0;
  logic signed [7:0] set_a, set_b;
  logic pol_a, pol_b, home;

  int errors = 0, checks = 0;
  string cur_req = "R13";
  bit running = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ustep_seq u_ustep_seq (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_cw(dir_cw),
    .res_code(res_code), .torque_code(torque_code), .div_code(div_code),
    .enable(enable), .angle_rst(angle_rst), .set_a(set_a), .set_b(set_b),
    .pol_a(pol_a), .pol_b(pol_b), .home(home));

  // ---------- behavioural reference ----------
  int m_idx = 16, m_cnt = 0;
  bit m_prev = 0;

  function automatic int ref_step(int r);
    case (r)
      1: return 32; 2: return 16; 4: return 16; 3: return 8;
      5: return 4;  6: return 2;  7: return 1;  default: return 0;
    endcase
  endfunction

  function automatic int ref_mag(int r, int k);
    int q8 [5] = '{0, 38, 71, 100, 100};
    int e8 [9] = '{0, 20, 38, 56, 71, 83, 96, 98, 100};
    int kk;
    case (r)
      1, 2: return (k == 0) ? 0 : 100;
      4: return (k == 0) ? 0 : ((k == 32) ? 100 : 71);
      3: return q8[k / 8];
      5: return e8[k / 4];
      6, 7: begin
        kk = (r == 6) ? (k / 2) * 2 : k;
        return $rtoi(100.0 * $sin(kk * 3.14159265358979 / 64.0) + 0.5);
      end
      default: return 0;
    endcase
  endfunction

  function automatic int ref_scale(int m, int tq);
    int pct [4] = '{40, 60, 80, 100};
    return (m * pct[tq]) / 100;
  endfunction

  function automatic int ref_set(bit sine);
    int q, k, m, s;
    if (!enable || res_code == 0) return 0;
    q = m_idx / 32; k = m_idx % 32;
    if (sine) begin
      m = (q % 2 == 0) ? ref_mag(res_code, k) : ref_mag(res_code, 32 - k);
      s = (q >= 2) ? -1 : 1;
    end else begin
      m = (q % 2 == 0) ? ref_mag(res_code, 32 - k) : ref_mag(res_code, k);
      s = (q == 1 || q == 2) ? -1 : 1;
    end
    return s * ref_scale(m, torque_code);
  endfunction

  always @(posedge clk) begin
    bit r;
    if (!rst_n) begin
      m_idx = 16; m_cnt = 0; m_prev = 0;
    end else begin
      r = step_in && !m_prev;
      m_prev = step_in;
      if (angle_rst) begin
        m_idx = 16; m_cnt = 0;
      end else if (r && res_code != 0) begin
        if (m_cnt % (1 << div_code) == (1 << div_code) - 1)
          m_idx = dir_cw ? (m_idx + ref_step(res_code)) % 128
                         : (m_idx + 128 - ref_step(res_code)) % 128;
        m_cnt = (m_cnt + 1) % 8;
      end
    end
  end

  task automatic check_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from both edges
  always @(negedge clk) begin
    int ea, eb;
    #3;
    if (running && rst_n) begin
      ea = ref_set(1'b0); eb = ref_set(1'b1);
      check_int(cur_req, "set_a", set_a, ea);
      check_int(cur_req, "set_b", set_b, eb);
      check_int("R12", "pol_a", pol_a, ea > 0);
      check_int("R12", "pol_b", pol_b, eb > 0);
      check_int("R13", "home", home, m_idx == 16);
    end
  end

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) step_in = 1'b1;
      @(negedge clk);
      @(negedge clk) step_in = 1'b0;
    end
  endtask

  task automatic go_home();
    @(negedge clk) angle_rst = 1'b1;
    @(negedge clk) angle_rst = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk); #5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    sample();
    // R13 / R3: reset state, standby outputs zero
    check_int("R13", "home after reset", home, 1);
    check_int("R3", "standby set_a", set_a, 0);

    // R3: standby ignores steps
    cur_req = "R3";
    pulse(3);
    @(negedge clk) begin res_code = 3'd7; enable = 1'b1; end
    sample();
    check_int("R3", "standby froze angle", home, 1);

    // R4 / R6: full step at home
    cur_req = "R6";
    @(negedge clk) res_code = 3'd1;
    sample();
    check_int("R4", "full home set_a", set_a, 100);
    check_int("R4", "full home set_b", set_b, 100);
    // R5: one CW full step -> 135 deg
    cur_req = "R5";
    pulse(1); sample();
    check_int("R5", "135deg set_a", set_a, -100);
    check_int("R5", "135deg set_b", set_b, 100);
    pulse(6);
    @(negedge clk) dir_cw = 1'b0;
    pulse(6);
    @(negedge clk) dir_cw = 1'b1;

    // R6: half A axis and half B
    go_home();
    @(negedge clk) res_code = 3'd2;
    pulse(1); sample();
    check_int("R6", "halfA axis set_a", set_a, 0);
    check_int("R12", "halfA axis pol_a", pol_a, 0);
    check_int("R6", "halfA axis set_b", set_b, 100);
    pulse(9);
    go_home();
    @(negedge clk) res_code = 3'd4;
    sample();
    check_int("R4", "halfB home set_a", set_a, 71);
    pulse(10);

    // R7: quarter and 1/8
    cur_req = "R7";
    go_home();
    @(negedge clk) res_code = 3'd3;
    pulse(1); sample();
    check_int("R7", "quarter 67.5 set_a", set_a, 38);
    check_int("R7", "quarter 67.5 set_b", set_b, 100);
    // R9: torque 40%
    @(negedge clk) torque_code = 2'd0;
    sample();
    check_int("R9", "torque40 set_a", set_a, 15);
    check_int("R9", "torque40 set_b", set_b, 40);
    cur_req = "R9";
    for (int t = 0; t < 4; t++) begin
      @(negedge clk) torque_code = 2'(t);
      pulse(5);
    end
    cur_req = "R7";
    go_home();
    @(negedge clk) res_code = 3'd5;
    pulse(3); sample();
    check_int("R7", "eighth set_b", set_b, 98);
    check_int("R7", "eighth set_a", set_a, 20);
    pulse(40);

    // R8: 1/16 and 1/32
    cur_req = "R8";
    go_home();
    @(negedge clk) res_code = 3'd7;
    pulse(1);
    @(negedge clk) res_code = 3'd6;
    sample();
    check_int("R8", "1/16 odd set_b", set_b, 71);
    check_int("R8", "1/16 odd set_a", set_a, 63);
    pulse(1); sample();
    check_int("R8", "1/16 even set_b", set_b, 77);
    pulse(70);
    @(negedge clk) begin res_code = 3'd7; dir_cw = 1'b0; end
    cur_req = "R2";
    pulse(135);
    @(negedge clk) dir_cw = 1'b1;
    pulse(20);

    // R10: divide by 8
    cur_req = "R10";
    go_home();
    @(negedge clk) div_code = 2'd3;
    pulse(7); sample();
    check_int("R10", "div8 after 7", home, 1);
    pulse(1); sample();
    check_int("R10", "div8 after 8", home, 0);
    for (int d = 1; d < 3; d++) begin
      @(negedge clk) div_code = 2'(d);
      pulse(9);
    end
    @(negedge clk) div_code = 2'd0;

    // R11: enable low
    cur_req = "R11";
    go_home();
    @(negedge clk) enable = 1'b0;
    pulse(2); sample();
    check_int("R11", "disabled set_a", set_a, 0);
    check_int("R11", "disabled pol_b", pol_b, 0);
    check_int("R11", "disabled still steps", home, 0);
    @(negedge clk) enable = 1'b1;

    // R1 / R4: edge during angle reset, then a held level and its fall
    cur_req = "R1";
    @(negedge clk) angle_rst = 1'b1;
    @(negedge clk) step_in = 1'b1;
    @(negedge clk) angle_rst = 1'b0;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    sample();
    check_int("R1", "level and fall ignored", home, 1);
    pulse(1); sample();
    check_int("R1", "rising edge moves", home, 0);

    repeat (3) @(negedge clk);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule